// File: doc/BRIEF.md
# Per-Task Link Register Capture

This block sits beside the register file of a processor core that interleaves up to four hardware tasks. When the core retires a subroutine call, it presents a call event: the call flavour, the issuing task and the return address. A five-bit enable mask holds one bit per call flavour. If the bit for the event's flavour is set, the block copies the zero-extended return address into a link register. The call's normal stack push is not affected and still happens elsewhere in the core. Compiled code can then return from a leaf routine through that register and never read the stack.

The link registers are four 32-bit flip-flop slots. They appear in the core's 9-bit register address space, and the block also translates the addresses of ordinary register accesses so that each task reaches its own slot. Three address layouts are available:

- **Shared:** the link register is address 0, and every task uses that one slot.
- **Task-expanded:** a task's access to address 0 goes to address 0 plus its task number.
- **Window:** a fixed four-register window is remapped on every access, with the two low address bits replaced by the task number.

Ordinary writes that land on a slot update it. Reads that land on a slot return its contents one cycle later.

Top module: `lrc_top`

## Requirements
- R1: After reset the enable mask is all zeros and all four slots hold zero, so calls of every flavour leave every link read at zero until the mask is loaded.
- R2: When `cfgWrEn` is high, the mask loads from `cfgMask`, and the new mask governs calls from the next cycle on. Flavour codes are 0 and 1 for main-memory stack calls, 2 and 3 for auxiliary-memory stack calls, and 4 for the internal hardware stack call. A call captures only when bit k of the mask is set for flavour code k, and codes 5 to 7 never capture.
- R3: A captured value is the return address in the low `RET_W` bits, with zeros in all upper bits.
- R4: With `winMode`=0 and `remapEn`=0 (shared layout), every capture goes to slot 0, and an access to address 0 from any task resolves to physical address 0.
- R5: With `winMode`=0 and `remapEn`=1 (task-expanded layout), a capture from task t goes to slot t, and address 0 from task t resolves to physical address t. Addresses 1 to 3 are not substituted.
- R6: With `winMode`=1, any access whose bits [8:2] match bits [8:2] of `WIN_BASE` (default 0x1F0) has bits [1:0] replaced by the task number. A capture from task t goes to window slot t whatever the value of `remapEn`.
- R7: An access outside the owned range passes through with its address unchanged. The owned range is physical addresses 0 to 3 when `winMode`=0, and the window when `winMode`=1. A read outside the owned range gives `rdHit`=0 and `rdData`=0 in the following cycle.
- R8: An ordinary write whose physical address is owned updates that slot. If a capture targets the same slot in the same cycle, the capture value is stored.
- R9: A read of an owned address sets `rdHit` and returns the slot in `rdData` exactly one cycle after `regRdEn`. If a write to the same slot happens in that cycle, the read returns the slot's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load the enable mask |
| cfgMask | input | 5 | New enable mask, one bit per call flavour |
| remapEn | input | 1 | Task-expanded addressing when not in window mode |
| winMode | input | 1 | Select the fixed remapped window layout |
| callValid | input | 1 | A call event is present |
| callKind | input | 3 | Call flavour code |
| callTask | input | 2 | Task that issued the call |
| callRet | input | 20 | Return address of the call |
| regWrEn | input | 1 | Ordinary register write strobe |
| regWrAddr | input | 9 | Logical write address |
| regWrTask | input | 2 | Task issuing the write |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Ordinary register read strobe |
| regRdAddr | input | 9 | Logical read address |
| regRdTask | input | 2 | Task issuing the read |
| rdPhysAddr | output | 9 | Translated read address |
| wrPhysAddr | output | 9 | Translated write address |
| rdHit | output | 1 | Previous-cycle read landed on a link slot |
| rdData | output | 32 | Link slot contents for that read, zero on a miss |

## Verification
The assertions check the address translation on every cycle, in all three layouts:

- window substitution;
- the address-0 expansion;
- the shared address 0;
- pass-through of every other address.

They also check that a read hit appears only after a read request, and that a miss returns zero data.

Other behaviour can only be shown by the bench scenarios, which compare against the reference model on every cycle:

- whether a given flavour captures under a given mask;
- the one-cycle delay before a mask load takes effect;
- zero filling of the return address;
- priority of a capture over a colliding ordinary write;
- the pre-write value returned by a read that coincides with a write.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  // Hardware task count fixes the slot count and the width of a slot index.
  localparam int NUM_TASKS = 4;
  localparam int TASK_W    = $clog2(NUM_TASKS);

  // Call flavours: the code value selects the matching enable-mask bit.
  localparam int NUM_KINDS = 5;
  localparam int KIND_W    = $clog2(NUM_KINDS);

  typedef enum logic [KIND_W-1:0] {
    KIND_MAIN_A = 3'd0,
    KIND_MAIN_B = 3'd1,
    KIND_AUX_X  = 3'd2,
    KIND_AUX_Y  = 3'd3,
    KIND_HWSTK  = 3'd4
  } call_kind_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              capEn;
    logic [TASK_W-1:0] capSlot;
    logic              swEn;
    logic [TASK_W-1:0] swSlot;
    logic              rdEn;
    logic [TASK_W-1:0] rdSlot;
  } lrc_strobe_t;

endpackage

// File: rtl/lrc_ctrl.sv
module lrc_ctrl
  import lrc_pkg::*;
#(
  parameter int               ADDR_W   = 9,
  parameter logic [ADDR_W-1:0] WIN_BASE = 9'h1F0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWrEn,
  input  logic [NUM_KINDS-1:0] cfgMask,
  input  logic                 remapEn,
  input  logic                 winMode,
  input  logic                 callValid,
  input  logic [KIND_W-1:0]    callKind,
  input  logic [TASK_W-1:0]    callTask,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regWrAddr,
  input  logic [TASK_W-1:0]    regWrTask,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regRdAddr,
  input  logic [TASK_W-1:0]    regRdTask,
  output lrc_strobe_t          strobe,
  output logic [ADDR_W-1:0]    rdPhysAddr,
  output logic [ADDR_W-1:0]    wrPhysAddr
);

  localparam int UP_W = ADDR_W - TASK_W;
  localparam logic [UP_W-1:0] WIN_UP  = WIN_BASE[ADDR_W-1:TASK_W];
  localparam logic [UP_W-1:0] ZERO_UP = '0;

  // Enable mask, one bit per call flavour; loaded by the config strobe.
  logic [NUM_KINDS-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rst_n)       maskQ <= '0;
    else if (cfgWrEn) maskQ <= cfgMask;
  end

  // One-hot decode of the flavour code; codes past the last flavour decode to nothing.
  logic [NUM_KINDS-1:0] kindHit;

  generate
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      assign kindHit[k] = (callKind == KIND_W'(k));
    end
  endgenerate

  // Logical-to-physical translation under the current layout.
  function automatic logic [ADDR_W-1:0] xlat(
    input logic [ADDR_W-1:0] a,
    input logic [TASK_W-1:0] t,
    input logic              wm,
    input logic              re
  );
    logic [ADDR_W-1:0] r;
    r = a;
    if (wm) begin
      if (a[ADDR_W-1:TASK_W] == WIN_UP) r = {WIN_UP, t};
    end else if (re && (a == '0)) begin
      r = {ZERO_UP, t};
    end
    return r;
  endfunction

  function automatic logic owned(
    input logic [ADDR_W-1:0] p,
    input logic              wm
  );
    return wm ? (p[ADDR_W-1:TASK_W] == WIN_UP) : (p[ADDR_W-1:TASK_W] == ZERO_UP);
  endfunction

  logic rdOwned;
  logic wrOwned;

  always_comb begin
    rdPhysAddr = xlat(regRdAddr, regRdTask, winMode, remapEn);
    wrPhysAddr = xlat(regWrAddr, regWrTask, winMode, remapEn);
    rdOwned    = owned(rdPhysAddr, winMode);
    wrOwned    = owned(wrPhysAddr, winMode);
  end

  // Strobe generation.
  always_comb begin
    strobe         = '0;
    strobe.capEn   = callValid && (|(kindHit & maskQ));
    strobe.capSlot = (winMode || remapEn) ? callTask : '0;
    strobe.swEn    = regWrEn && wrOwned;
    strobe.swSlot  = wrPhysAddr[TASK_W-1:0];
    strobe.rdEn    = regRdEn && rdOwned;
    strobe.rdSlot  = rdPhysAddr[TASK_W-1:0];
  end

endmodule

// File: rtl/lrc_dpath.sv
module lrc_dpath
  import lrc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RET_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lrc_strobe_t       strobe,
  input  logic [RET_W-1:0]  callRet,
  input  logic [DATA_W-1:0] regWrData,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - RET_W;

  // Zero-extended return address.
  logic [DATA_W-1:0] capValue;

  generate
    if (PAD_W > 0) begin : g_pad
      assign capValue = {{PAD_W{1'b0}}, callRet};
    end else begin : g_nopad
      assign capValue = callRet[DATA_W-1:0];
    end
  endgenerate

  logic [DATA_W-1:0] slotQ [NUM_TASKS];

  // Per-slot storage; a capture takes priority over an ordinary write.
  generate
    for (genvar i = 0; i < NUM_TASKS; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slotQ[i] <= '0;
        end else if (strobe.capEn && (strobe.capSlot == TASK_W'(i))) begin
          slotQ[i] <= capValue;
        end else if (strobe.swEn && (strobe.swSlot == TASK_W'(i))) begin
          slotQ[i] <= regWrData;
        end
      end
    end
  endgenerate

  // Registered read port: returns the slot value from before this edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdHit  <= 1'b0;
      rdData <= '0;
    end else begin
      rdHit  <= strobe.rdEn;
      rdData <= strobe.rdEn ? slotQ[strobe.rdSlot] : '0;
    end
  end

endmodule

// File: rtl/lrc_top.sv
module lrc_top
  import lrc_pkg::*;
#(
  parameter int                ADDR_W   = 9,
  parameter int                DATA_W   = 32,
  parameter int                RET_W    = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 9'h1F0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWrEn,
  input  logic [NUM_KINDS-1:0] cfgMask,
  input  logic                 remapEn,
  input  logic                 winMode,
  input  logic                 callValid,
  input  logic [KIND_W-1:0]    callKind,
  input  logic [TASK_W-1:0]    callTask,
  input  logic [RET_W-1:0]     callRet,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regWrAddr,
  input  logic [TASK_W-1:0]    regWrTask,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regRdAddr,
  input  logic [TASK_W-1:0]    regRdTask,
  output logic [ADDR_W-1:0]    rdPhysAddr,
  output logic [ADDR_W-1:0]    wrPhysAddr,
  output logic                 rdHit,
  output logic [DATA_W-1:0]    rdData
);

  lrc_strobe_t strobe;

  lrc_ctrl #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgMask   (cfgMask),
    .remapEn   (remapEn),
    .winMode   (winMode),
    .callValid (callValid),
    .callKind  (callKind),
    .callTask  (callTask),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrTask (regWrTask),
    .regRdEn   (regRdEn),
    .regRdAddr (regRdAddr),
    .regRdTask (regRdTask),
    .strobe    (strobe),
    .rdPhysAddr(rdPhysAddr),
    .wrPhysAddr(wrPhysAddr)
  );

  lrc_dpath #(
    .DATA_W(DATA_W),
    .RET_W (RET_W)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .callRet  (callRet),
    .regWrData(regWrData),
    .rdHit    (rdHit),
    .rdData   (rdData)
  );

endmodule

// File: rtl/lrc_chk.sv
module lrc_chk
  import lrc_pkg::*;
#(
  parameter int                ADDR_W   = 9,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 9'h1F0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              winMode,
  input logic              remapEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regRdAddr,
  input logic [TASK_W-1:0] regRdTask,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic [ADDR_W-1:0] rdPhysAddr,
  input logic [ADDR_W-1:0] wrPhysAddr,
  input logic              rdHit,
  input logic [DATA_W-1:0] rdData
);

  localparam int UP_W = ADDR_W - TASK_W;
  localparam logic [UP_W-1:0] WIN_UP = WIN_BASE[ADDR_W-1:TASK_W];

  // R6
  win_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (winMode && (regRdAddr[ADDR_W-1:TASK_W] == WIN_UP)) |->
      (rdPhysAddr == {WIN_UP, regRdTask}));

  // R5
  expand_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!winMode && remapEn && (regRdAddr == '0)) |->
      (rdPhysAddr[ADDR_W-1:TASK_W] == '0 && rdPhysAddr[TASK_W-1:0] == regRdTask));

  // R4
  shared_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!winMode && !remapEn && (regWrAddr == '0)) |-> (wrPhysAddr == '0));

  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!winMode && (regRdAddr != '0)) ||
     (winMode && (regRdAddr[ADDR_W-1:TASK_W] != WIN_UP))) |-> (rdPhysAddr == regRdAddr));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdHit |-> (rdData == '0));

  // R9
  hit_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdHit |-> $past(regRdEn));

endmodule

bind lrc_top lrc_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .WIN_BASE(WIN_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .winMode   (winMode),
  .remapEn   (remapEn),
  .regRdEn   (regRdEn),
  .regRdAddr (regRdAddr),
  .regRdTask (regRdTask),
  .regWrAddr (regWrAddr),
  .rdPhysAddr(rdPhysAddr),
  .wrPhysAddr(wrPhysAddr),
  .rdHit     (rdHit),
  .rdData    (rdData)
);

// File: tb/lrc_top_tb.sv
module lrc_top_tb;

  localparam int AW = 9;
  localparam int DW = 32;
  localparam int RW = 20;
  localparam logic [8:0] WB = 9'h1F0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          cfgWrEn;
  logic [4:0]    cfgMask;
  logic          remapEn;
  logic          winMode;
  logic          callValid;
  logic [2:0]    callKind;
  logic [1:0]    callTask;
  logic [RW-1:0] callRet;
  logic          regWrEn;
  logic [AW-1:0] regWrAddr;
  logic [1:0]    regWrTask;
  logic [DW-1:0] regWrData;
  logic          regRdEn;
  logic [AW-1:0] regRdAddr;
  logic [1:0]    regRdTask;
  logic [AW-1:0] rdPhysAddr;
  logic [AW-1:0] wrPhysAddr;
  logic          rdHit;
  logic [DW-1:0] rdData;

  lrc_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgMask(cfgMask),
    .remapEn(remapEn), .winMode(winMode), .callValid(callValid),
    .callKind(callKind), .callTask(callTask), .callRet(callRet),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrTask(regWrTask),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdAddr(regRdAddr),
    .regRdTask(regRdTask), .rdPhysAddr(rdPhysAddr), .wrPhysAddr(wrPhysAddr),
    .rdHit(rdHit), .rdData(rdData)
  );

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  bit    finished = 0;

  // Behavioural reference model.
  logic [4:0]  mMask;
  logic [31:0] mSlot [4];
  logic        mHit;
  logic [31:0] mData;

  function automatic logic [8:0] mXlat(logic [8:0] a, logic [1:0] t, logic wm, logic re);
    if (wm && a[8:2] == WB[8:2]) return {WB[8:2], t};
    if (!wm && re && a == 9'd0) return {7'd0, t};
    return a;
  endfunction

  function automatic bit mOwns(logic [8:0] p, logic wm);
    return wm ? (p[8:2] == WB[8:2]) : (p[8:2] == 7'd0);
  endfunction

  task automatic check32(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mMask = '0;
    mHit  = 1'b0;
    mData = '0;
    for (int i = 0; i < 4; i++) mSlot[i] = '0;
  endtask

  task automatic modelStep();
    logic [8:0] rp;
    logic [8:0] wp;
    rp = mXlat(regRdAddr, regRdTask, winMode, remapEn);
    wp = mXlat(regWrAddr, regWrTask, winMode, remapEn);
    mHit  = regRdEn && mOwns(rp, winMode);
    mData = mHit ? mSlot[rp[1:0]] : 32'd0;
    if (regWrEn && mOwns(wp, winMode)) mSlot[wp[1:0]] = regWrData;
    if (callValid && callKind < 3'd5 && mMask[callKind])
      mSlot[(winMode || remapEn) ? callTask : 2'd0] = {12'd0, callRet};
    if (cfgWrEn) mMask = cfgMask;
  endtask

  // One clock: address checks before the edge, registered checks after it.
  task automatic tick();
    #1;
    check32("rdPhysAddr", 32'(rdPhysAddr), 32'(mXlat(regRdAddr, regRdTask, winMode, remapEn)));
    check32("wrPhysAddr", 32'(wrPhysAddr), 32'(mXlat(regWrAddr, regWrTask, winMode, remapEn)));
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check32("rdHit", 32'(rdHit), 32'(mHit));
    check32("rdData", rdData, mData);
  endtask

  task automatic idle();
    cfgWrEn = 0; callValid = 0; regWrEn = 0; regRdEn = 0;
  endtask

  task automatic doCall(logic [2:0] k, logic [1:0] t, logic [RW-1:0] r);
    callValid = 1; callKind = k; callTask = t; callRet = r;
    tick();
    idle();
  endtask

  task automatic doWrite(logic [8:0] a, logic [1:0] t, logic [31:0] d);
    regWrEn = 1; regWrAddr = a; regWrTask = t; regWrData = d;
    tick();
    idle();
  endtask

  task automatic expectRead(logic [8:0] a, logic [1:0] t, logic [31:0] exp);
    regRdEn = 1; regRdAddr = a; regRdTask = t;
    tick();
    idle();
    check32("explicit rdHit", 32'(rdHit), 32'd1);
    check32("explicit rdData", rdData, exp);
  endtask

  task automatic expectMiss(logic [8:0] a, logic [1:0] t);
    regRdEn = 1; regRdAddr = a; regRdTask = t;
    #1;
    check32("passthru addr", 32'(rdPhysAddr), 32'(a));
    tick();
    idle();
    check32("miss rdHit", 32'(rdHit), 32'd0);
    check32("miss rdData", rdData, 32'd0);
  endtask

  task automatic setMask(logic [4:0] m);
    cfgWrEn = 1; cfgMask = m;
    tick();
    idle();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired in %s", curReq);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; remapEn = 1; winMode = 0; cfgMask = '0;
    callKind = '0; callTask = '0; callRet = '0;
    regWrAddr = '0; regWrTask = '0; regWrData = '0;
    regRdAddr = '0; regRdTask = '0;
    idle();
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state and an all-zero mask
    curReq = "R1";
    check32("reset rdHit", 32'(rdHit), 32'd0);
    check32("reset rdData", rdData, 32'd0);
    for (int k = 0; k < 5; k++) doCall(3'(k), 2'(k % 4), 20'hABC00 + 20'(k));
    for (int t = 0; t < 4; t++) expectRead(9'd0, 2'(t), 32'd0);

    // R2: mask load delay, per-flavour bits, unused codes
    curReq = "R2";
    cfgWrEn = 1; cfgMask = 5'b00101;
    callValid = 1; callKind = 3'd0; callTask = 2'd0; callRet = 20'h11111;
    tick();
    idle();
    expectRead(9'd0, 2'd0, 32'd0);
    doCall(3'd0, 2'd0, 20'h22222);
    doCall(3'd1, 2'd1, 20'h33333);
    doCall(3'd2, 2'd2, 20'h44444);
    doCall(3'd5, 2'd3, 20'h99999);
    doCall(3'd7, 2'd3, 20'h99999);
    expectRead(9'd0, 2'd0, 32'h00022222);
    expectRead(9'd0, 2'd1, 32'd0);
    expectRead(9'd0, 2'd2, 32'h00044444);
    expectRead(9'd0, 2'd3, 32'd0);
    setMask(5'b11111);
    doCall(3'd4, 2'd3, 20'h55555);
    doCall(3'd3, 2'd1, 20'h66666);
    expectRead(9'd0, 2'd3, 32'h00055555);
    expectRead(9'd0, 2'd1, 32'h00066666);

    // R3: zero fill of upper bits
    curReq = "R3";
    doCall(3'd4, 2'd2, 20'hFFFFF);
    expectRead(9'd0, 2'd2, 32'h000FFFFF);

    // R5: task-expanded layout
    curReq = "R5";
    doCall(3'd0, 2'd0, 20'h10000);
    doCall(3'd1, 2'd1, 20'h20001);
    doCall(3'd2, 2'd2, 20'h30002);
    doCall(3'd3, 2'd3, 20'h40003);
    for (int t = 0; t < 4; t++) expectRead(9'd0, 2'(t), 32'h10000 * (t + 1) + 32'(t));
    expectRead(9'd1, 2'd3, 32'h00020001);

    // R4: shared layout
    curReq = "R4";
    remapEn = 0;
    doCall(3'd2, 2'd3, 20'h0A0A0);
    expectRead(9'd0, 2'd1, 32'h000A0A0);
    expectRead(9'd0, 2'd3, 32'h000A0A0);
    expectRead(9'd3, 2'd0, 32'h00040003);

    // R6: window layout
    curReq = "R6";
    winMode = 1; remapEn = 1;
    doCall(3'd1, 2'd2, 20'h12345);
    expectRead(9'h1F0, 2'd2, 32'h00012345);
    expectRead(9'h1F3, 2'd2, 32'h00012345);
    expectRead(9'h1F1, 2'd0, 32'h000A0A0);
    remapEn = 0;
    doCall(3'd1, 2'd3, 20'h07777);
    expectRead(9'h1F0, 2'd3, 32'h00007777);

    // R7: addresses outside the owned range
    curReq = "R7";
    expectMiss(9'h000, 2'd0);
    winMode = 0; remapEn = 1;
    expectMiss(9'h055, 2'd1);
    expectMiss(9'h1F2, 2'd2);

    // R8: ordinary writes and capture priority
    curReq = "R8";
    doWrite(9'd2, 2'd0, 32'hDEADBEEF);
    expectRead(9'd0, 2'd2, 32'hDEADBEEF);
    doWrite(9'd0, 2'd3, 32'h00003333);
    expectRead(9'd3, 2'd0, 32'h00003333);
    regWrEn = 1; regWrAddr = 9'd0; regWrTask = 2'd1; regWrData = 32'hCAFEF00D;
    callValid = 1; callKind = 3'd4; callTask = 2'd1; callRet = 20'h0BEEF;
    tick();
    idle();
    expectRead(9'd0, 2'd1, 32'h0000BEEF);

    // R9: latency and read-before-write ordering
    curReq = "R9";
    regRdEn = 1; regRdAddr = 9'd0; regRdTask = 2'd2;
    regWrEn = 1; regWrAddr = 9'd0; regWrTask = 2'd2; regWrData = 32'h5A5A5A5A;
    tick();
    idle();
    check32("read old value", rdData, 32'hDEADBEEF);
    check32("hit one cycle later", 32'(rdHit), 32'd1);
    tick();
    check32("hit drops after idle", 32'(rdHit), 32'd0);
    expectRead(9'd0, 2'd2, 32'h5A5A5A5A);

    finished = 1;
    summary();
    $finish;
  end

endmodule